// File: doc/BRIEF.md
# ADC Output Test Pattern Path

This block sits between a 14-bit converter core and its parallel output pins. On every valid sample it either passes the live conversion word through or substitutes one of several test sources. The sources are fixed codes, alternating words, a walking one, two pseudo-random sequences and a pair of user-supplied words. The chosen word is then re-encoded into the selected output number format and can be bit-inverted. One register stage separates the inputs from the output pins.

The user-word source is driven by a small sequencer with three states. `SQ_FIRST` presents pattern A, `SQ_SECOND` presents pattern B, and `SQ_DONE` presents midscale. The sequencer steps only on valid samples while the user source is selected.

In the looping-single mode, `SQ_FIRST` goes back to `SQ_FIRST`. In the looping-pair mode, `SQ_FIRST` goes to `SQ_SECOND` and `SQ_SECOND` returns to `SQ_FIRST`. In the single-once mode, `SQ_FIRST` goes to `SQ_DONE`. In the pair-once mode, `SQ_FIRST` goes to `SQ_SECOND` and `SQ_SECOND` goes to `SQ_DONE`. `SQ_DONE` stays in `SQ_DONE`. A configuration restart forces the sequencer to behave as `SQ_FIRST` on the next valid sample. If the sequencer is ever in `SQ_SECOND` under a single-word mode, it falls back to `SQ_FIRST`.

Top module: `adc_tpat_path`

## Requirements
- R1: After reset `dout` is 0x0000. `dout` changes only at a clock edge where `smp_vld` is high, and it then shows the word selected from the inputs present at that edge. With `smp_vld` low, `dout` holds.
- R2: Source code 0000 passes `smp_in` through. `smp_in` is taken as offset binary.
- R3: Some source codes give constant words, written here in offset binary. Code 0001 gives 0x2000 and code 0010 gives 0x3FFF. Code 0011 gives 0x0000 and code 1001 gives 0x2AAA. Code 1010 gives 0x007F. Unused codes 1101 to 1111 give 0x2000.
- R4: Some source codes alternate between two words on successive valid samples, starting with the first word listed. Code 0100 alternates 0x2AAA and 0x1555. Code 0111 alternates 0x3FFF and 0x0000. Code 1100 alternates 0x3C3C and 0x03C3.
- R5: Code 1011 outputs a walking one. The set bit is bit 0 on the first valid sample, then bit 1, and so on up to bit 13. After bit 13 it wraps back to bit 0.
- R6: The long generator is a 23-bit register seeded to all ones. On each valid sample it shifts toward the MSB and takes in bit22 XOR bit17 as its new bit 0. While `pn_long_clr` is high it stays at the seed. Code 0101 outputs register bits 22:9 as they stand before the shift.
- R7: The short generator is a 9-bit register seeded to all ones. On each valid sample it shifts toward the MSB and takes in bit8 XOR bit4 as its new bit 0. While `pn_short_clr` is high it stays at the seed. Code 0110 outputs {reg[8:0], reg[8:4]} as they stand before the shift.
- R8: Code 1000 outputs user words. Pattern A is {`upat_a_hi`,`upat_a_lo`} and pattern B is {`upat_b_hi`,`upat_b_lo`}. The output takes pattern bits 15:2. With `useq` 00 the output is A on every sample. With `useq` 01 the output alternates A, B, A, and so on.
- R9: With `useq` 10 the output is A once and then 0x2000. With `useq` 11 the output is A, then B, then 0x2000. In both modes the output stays at 0x2000 until `tmode` or `useq` changes.
- R10: A change in `tmode` or `useq` restarts the alternation phase, the walking-one position and the user sequence. The restart takes effect on the next valid sample.
- R11: `fmt` selects the output encoding. 00 and 11 give offset binary. 01 gives two's complement, which is the word with bit 13 flipped. 10 gives Gray code, which is w XOR (w>>1).
- R12: When `inv_en` is high, every output bit is complemented after the format conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_in | input | 14 | Live conversion word, offset binary |
| smp_vld | input | 1 | Sample strobe |
| tmode | input | 4 | Source select |
| useq | input | 2 | User-word sequencing mode |
| pn_long_clr | input | 1 | Holds the 23-bit generator at its seed |
| pn_short_clr | input | 1 | Holds the 9-bit generator at its seed |
| upat_a_lo | input | 8 | Pattern A low byte |
| upat_a_hi | input | 8 | Pattern A high byte |
| upat_b_lo | input | 8 | Pattern B low byte |
| upat_b_hi | input | 8 | Pattern B high byte |
| fmt | input | 2 | Output number format |
| inv_en | input | 1 | Complement all output bits |
| dout | output | 14 | Registered formatted output word |

## Verification
Live words with distinct bit patterns show whether pass-through is exact. These words are also fed through every encoding, with and without inversion, so that a two's-complement flip, a Gray shift and an inversion each leave their own signature. Runs of twenty or more PN samples compared against a model tell a wrong tap or a wrong bit mapping apart from a wrong seed, and clearing while samples continue shows that the reset holds the generator. User words whose A and B differ in every nibble expose an early, late or missing step to `SQ_DONE` in each sequencing mode. A mode switch made in mid-alternation shows whether the phase restarts.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
    localparam int DW   = 14;
    localparam int UPW  = 16;

    typedef enum logic [3:0] {
        TM_LIVE   = 4'b0000,
        TM_MID    = 4'b0001,
        TM_PFS    = 4'b0010,
        TM_NFS    = 4'b0011,
        TM_CHECK  = 4'b0100,
        TM_PNL    = 4'b0101,
        TM_PNS    = 4'b0110,
        TM_WTOG   = 4'b0111,
        TM_USER   = 4'b1000,
        TM_BTOG   = 4'b1001,
        TM_SYNC   = 4'b1010,
        TM_WALK   = 4'b1011,
        TM_MIXED  = 4'b1100
    } tmode_e;

    typedef enum logic [1:0] {
        FMT_OB  = 2'b00,
        FMT_TC  = 2'b01,
        FMT_GR  = 2'b10,
        FMT_OB2 = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        SQ_ONE_LOOP  = 2'b00,
        SQ_PAIR_LOOP = 2'b01,
        SQ_ONE_ONCE  = 2'b10,
        SQ_PAIR_ONCE = 2'b11
    } useq_e;

    typedef enum logic [1:0] {
        SQ_FIRST  = 2'd0,
        SQ_SECOND = 2'd1,
        SQ_DONE   = 2'd2
    } seq_st_e;

    // alternating bits; odd=1 sets the odd positions
    function automatic logic [DW-1:0] alt_bits(input logic odd);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = (i % 2 == 1) ? odd : ~odd;
        return r;
    endfunction

    // groups of four set bits at positions 2..5 of every byte
    function automatic logic [DW-1:0] mixed_bits();
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = ((i % 8) >= 2) && ((i % 8) <= 5);
        return r;
    endfunction
endpackage

// File: rtl/tpat_pn_lfsr.sv
module tpat_pn_lfsr #(
    parameter int LEN   = 23,
    parameter int TAP   = 18,
    parameter int OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [OUT_W-1:0] word
);
    logic [LEN-1:0] st;
    logic [LEN-1:0] st_nx;

    always_comb begin
        st_nx = {st[LEN-2:0], st[LEN-1] ^ st[TAP-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st <= '1;
        else if (clr)  st <= '1;
        else if (adv)  st <= st_nx;
    end

    // output bit i takes register bit counted down from the MSB, wrapping
    // around the register when it is shorter than the word
    for (genvar i = 0; i < OUT_W; i++) begin : g_map
        localparam int SRC = (LEN - 1) - ((OUT_W - 1 - i) % LEN);
        assign word[i] = st[SRC];
    end
endmodule

// File: rtl/tpat_user_seq.sv
module tpat_user_seq
    import tpat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       restart,
    input  logic [1:0] seq_mode,
    output logic       sel_b,
    output logic       done
);
    seq_st_e st, eff, nxt;
    useq_e   mode;

    assign mode = useq_e'(seq_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st <= SQ_FIRST;
        else if (step) st <= nxt;
    end

    always_comb begin
        eff = restart ? SQ_FIRST : st;
        nxt = SQ_FIRST;
        unique case (eff)
            SQ_FIRST: begin
                unique case (mode)
                    SQ_ONE_LOOP:  nxt = SQ_FIRST;
                    SQ_PAIR_LOOP: nxt = SQ_SECOND;
                    SQ_ONE_ONCE:  nxt = SQ_DONE;
                    SQ_PAIR_ONCE: nxt = SQ_SECOND;
                    default:      nxt = SQ_FIRST;
                endcase
            end
            SQ_SECOND: begin
                if (mode == SQ_PAIR_ONCE) nxt = SQ_DONE;
                else                      nxt = SQ_FIRST;
            end
            SQ_DONE:  nxt = SQ_DONE;
            default:  nxt = SQ_FIRST;
        endcase
        sel_b = (eff == SQ_SECOND);
        done  = (eff == SQ_DONE);
    end
endmodule

// File: rtl/tpat_fmt.sv
module tpat_fmt
    import tpat_pkg::*;
(
    input  logic [DW-1:0] w_in,
    input  logic [1:0]    fmt_sel,
    input  logic          inv,
    output logic [DW-1:0] w_out
);
    logic [DW-1:0] enc;

    always_comb begin
        unique case (fmt_e'(fmt_sel))
            FMT_TC:  enc = w_in ^ (DW'(1) << (DW - 1));
            FMT_GR:  enc = w_in ^ (w_in >> 1);
            default: enc = w_in;
        endcase
        w_out = inv ? ~enc : enc;
    end
endmodule

// File: rtl/adc_tpat_path.sv
module adc_tpat_path
    import tpat_pkg::*;
#(
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_in,
    input  logic          smp_vld,
    input  logic [3:0]    tmode,
    input  logic [1:0]    useq,
    input  logic          pn_long_clr,
    input  logic          pn_short_clr,
    input  logic [7:0]    upat_a_lo,
    input  logic [7:0]    upat_a_hi,
    input  logic [7:0]    upat_b_lo,
    input  logic [7:0]    upat_b_hi,
    input  logic [1:0]    fmt,
    input  logic          inv_en,
    output logic [DW-1:0] dout
);
    localparam int IW = $clog2(DW);
    localparam logic [DW-1:0] MID   = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] SYNCW = (DW'(1) << (DW / 2)) - DW'(1);

    // configuration change detection
    logic [5:0]    cfg_q;
    logic          pend;
    logic          chg;
    logic          restart;
    logic          ph;
    logic          eff_ph;
    logic [IW-1:0] widx;
    logic [IW-1:0] eff_idx;

    assign chg     = ({tmode, useq} != cfg_q);
    assign restart = pend | chg;
    assign eff_ph  = restart ? 1'b0 : ph;
    assign eff_idx = restart ? '0 : widx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            pend  <= 1'b1;
            ph    <= 1'b0;
            widx  <= '0;
        end else begin
            cfg_q <= {tmode, useq};
            pend  <= smp_vld ? 1'b0 : restart;
            if (smp_vld) begin
                ph   <= ~eff_ph;
                widx <= (eff_idx == IW'(DW - 1)) ? '0 : eff_idx + IW'(1);
            end
        end
    end

    // pseudo-random sources
    logic [DW-1:0] pn_l_word, pn_s_word;

    tpat_pn_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .OUT_W(DW)) u_pn_long (
        .clk(clk), .rst_n(rst_n), .clr(pn_long_clr), .adv(smp_vld), .word(pn_l_word)
    );

    tpat_pn_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .OUT_W(DW)) u_pn_short (
        .clk(clk), .rst_n(rst_n), .clr(pn_short_clr), .adv(smp_vld), .word(pn_s_word)
    );

    // user-word sequencing
    logic [UPW-1:0] pat_a, pat_b;
    logic           sel_b, seq_done;
    logic [DW-1:0]  user_word;
    logic           unused_lsbs;

    assign pat_a       = {upat_a_hi, upat_a_lo};
    assign pat_b       = {upat_b_hi, upat_b_lo};
    assign unused_lsbs = ^{pat_a[UPW-DW-1:0], pat_b[UPW-DW-1:0]};

    tpat_user_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .step(smp_vld && (tmode == TM_USER)),
        .restart(restart), .seq_mode(useq),
        .sel_b(sel_b), .done(seq_done)
    );

    always_comb begin
        if (seq_done)   user_word = MID;
        else if (sel_b) user_word = pat_b[UPW-1 -: DW];
        else            user_word = pat_a[UPW-1 -: DW];
    end

    // source selection
    logic [DW-1:0] src;

    always_comb begin
        unique case (tmode)
            TM_LIVE:  src = smp_in;
            TM_MID:   src = MID;
            TM_PFS:   src = '1;
            TM_NFS:   src = '0;
            TM_CHECK: src = alt_bits(~eff_ph);
            TM_PNL:   src = pn_l_word;
            TM_PNS:   src = pn_s_word;
            TM_WTOG:  src = eff_ph ? '0 : '1;
            TM_USER:  src = user_word;
            TM_BTOG:  src = alt_bits(1'b1);
            TM_SYNC:  src = SYNCW;
            TM_WALK:  src = DW'(1) << eff_idx;
            TM_MIXED: src = eff_ph ? ~mixed_bits() : mixed_bits();
            default:  src = MID;
        endcase
    end

    logic [DW-1:0] fmt_word;

    tpat_fmt u_fmt (.w_in(src), .fmt_sel(fmt), .inv(inv_en), .w_out(fmt_word));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (smp_vld) dout <= fmt_word;
    end
endmodule

// File: rtl/tpat_chk.sv
module tpat_chk
    import tpat_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] smp_in,
    input logic          smp_vld,
    input logic [3:0]    tmode,
    input logic [1:0]    fmt,
    input logic          inv_en,
    input logic [DW-1:0] dout
);
    logic plain;
    assign plain = (fmt == 2'b00) && !inv_en;

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(dout));

    a_r2_live_pass: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && tmode == 4'b0000 && plain |=> dout == $past(smp_in));

    a_r3_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && tmode == 4'b0001 && plain |=> dout == 14'h2000);

    a_r3_pos_full: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && tmode == 4'b0010 && plain |=> dout == 14'h3FFF);

    a_r5_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && tmode == 4'b1011 && plain |=> $countones(dout) == 1);

    a_r11_twos_mid: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && tmode == 4'b0001 && fmt == 2'b01 && !inv_en |=> dout == 14'h0000);

    a_r12_inv_neg: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && tmode == 4'b0011 && fmt == 2'b00 && inv_en |=> dout == 14'h3FFF);
endmodule

bind adc_tpat_path tpat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
    .tmode(tmode), .fmt(fmt), .inv_en(inv_en), .dout(dout)
);

// File: tb/sim_adc_tpat_path.sv
module sim_adc_tpat_path;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] smp_in = '0;
    logic        smp_vld = 1'b0;
    logic [3:0]  tmode = '0;
    logic [1:0]  useq = '0;
    logic        pn_long_clr = 1'b0;
    logic        pn_short_clr = 1'b0;
    logic [7:0]  upat_a_lo = '0, upat_a_hi = '0, upat_b_lo = '0, upat_b_hi = '0;
    logic [1:0]  fmt = '0;
    logic        inv_en = 1'b0;
    logic [13:0] dout;

    int checks = 0;
    int errors = 0;

    logic [22:0] m23 = '1;
    logic [8:0]  m9  = '1;

    always #(CLK_P/2) clk = ~clk;

    adc_tpat_path u0 (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
        .tmode(tmode), .useq(useq), .pn_long_clr(pn_long_clr),
        .pn_short_clr(pn_short_clr), .upat_a_lo(upat_a_lo), .upat_a_hi(upat_a_hi),
        .upat_b_lo(upat_b_lo), .upat_b_hi(upat_b_hi), .fmt(fmt),
        .inv_en(inv_en), .dout(dout)
    );

    function automatic logic [13:0] w23(input logic [22:0] s);
        return s[22:9];
    endfunction

    function automatic logic [13:0] w9(input logic [8:0] s);
        return {s, s[8:4]};
    endfunction

    task automatic check(input logic [13:0] act, input logic [13:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic vld);
        if (pn_long_clr)  m23 = '1;
        else if (vld)     m23 = {m23[21:0], m23[22] ^ m23[17]};
        if (pn_short_clr) m9 = '1;
        else if (vld)     m9 = {m9[7:0], m9[8] ^ m9[4]};
    endtask

    task automatic smp(input logic [13:0] d, input logic [13:0] exp, input string tag);
        smp_in  = d;
        smp_vld = 1'b1;
        @(posedge clk);
        model_edge(1'b1);
        #1;
        smp_vld = 1'b0;
        check(dout, exp, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge(1'b0);
            #1;
        end
    endtask

    task automatic t_reset;
        check(dout, 14'h0000, "R1 reset value");
    endtask

    task automatic t_live;
        tmode = 4'b0000; fmt = 2'b00; inv_en = 1'b0;
        smp(14'h1234, 14'h1234, "R2 live 1234");
        smp(14'h2ABC, 14'h2ABC, "R2 live 2ABC");
        smp_in = 14'h0F0F;
        idle(2);
        check(dout, 14'h2ABC, "R1 hold without strobe");
    endtask

    task automatic t_fixed;
        tmode = 4'b0001; smp(14'h0555, 14'h2000, "R3 midscale");
        tmode = 4'b0010; smp(14'h0555, 14'h3FFF, "R3 positive full");
        tmode = 4'b0011; smp(14'h0555, 14'h0000, "R3 negative full");
        tmode = 4'b1001; smp(14'h0555, 14'h2AAA, "R3 bit toggle");
        tmode = 4'b1010; smp(14'h0555, 14'h007F, "R3 sync");
        tmode = 4'b1110; smp(14'h0555, 14'h2000, "R3 unused code");
    endtask

    task automatic t_alt;
        tmode = 4'b0100;
        smp(0, 14'h2AAA, "R4 checker 0");
        smp(0, 14'h1555, "R4 checker 1");
        idle(1);
        smp(0, 14'h2AAA, "R4 checker 2");
        tmode = 4'b0111;
        smp(0, 14'h3FFF, "R4 word toggle 0");
        smp(0, 14'h0000, "R4 word toggle 1");
        tmode = 4'b1100;
        smp(0, 14'h3C3C, "R4 mixed 0");
        smp(0, 14'h03C3, "R4 mixed 1");
        smp(0, 14'h3C3C, "R4 mixed 2");
    endtask

    task automatic t_restart;
        tmode = 4'b0100;
        smp(0, 14'h2AAA, "R10 checker first");
        tmode = 4'b0111;
        smp(0, 14'h3FFF, "R10 toggle restarts phase");
        tmode = 4'b0100;
        idle(3);
        smp(0, 14'h2AAA, "R10 restart after idle");
    endtask

    task automatic t_walk;
        tmode = 4'b1011;
        for (int i = 0; i < 14; i++) smp(0, 14'(1) << i, $sformatf("R5 walk bit %0d", i));
        smp(0, 14'h0001, "R5 walk wrap");
        tmode = 4'b0000; idle(1); tmode = 4'b1011;
        smp(0, 14'h0001, "R10 walk restart");
    endtask

    task automatic t_pn_long;
        tmode = 4'b0101;
        pn_long_clr = 1'b1; idle(1); pn_long_clr = 1'b0;
        for (int i = 0; i < 30; i++) smp(14'(i), w23(m23), $sformatf("R6 pn23 step %0d", i));
        pn_long_clr = 1'b1;
        smp(0, w23(m23), "R6 pn23 clear edge");
        smp(0, 14'h3FFF, "R6 pn23 held at seed");
        smp(0, 14'h3FFF, "R6 pn23 still seed");
        pn_long_clr = 1'b0;
        for (int i = 0; i < 5; i++) smp(0, w23(m23), $sformatf("R6 pn23 resume %0d", i));
    endtask

    task automatic t_pn_short;
        tmode = 4'b0110;
        pn_short_clr = 1'b1; idle(1); pn_short_clr = 1'b0;
        smp(0, 14'h3FFF, "R7 pn9 seed word");
        for (int i = 0; i < 25; i++) smp(0, w9(m9), $sformatf("R7 pn9 step %0d", i));
        pn_short_clr = 1'b1;
        smp(0, w9(m9), "R7 pn9 clear edge");
        smp(0, 14'h3FFF, "R7 pn9 held at seed");
        pn_short_clr = 1'b0;
        smp(0, w9(m9), "R7 pn9 resume");
    endtask

    task automatic t_user;
        logic [13:0] a, b;
        upat_a_hi = 8'hAB; upat_a_lo = 8'hCD; upat_b_hi = 8'h12; upat_b_lo = 8'h37;
        a = 16'hABCD >> 2; b = 16'h1237 >> 2;
        tmode = 4'b1000; useq = 2'b00;
        smp(0, a, "R8 single loop 0");
        smp(0, a, "R8 single loop 1");
        smp(0, a, "R8 single loop 2");
        useq = 2'b01;
        smp(0, a, "R8 pair loop A");
        smp(0, b, "R8 pair loop B");
        smp(0, a, "R8 pair loop A again");
        useq = 2'b10;
        smp(0, a, "R9 single once A");
        smp(0, 14'h2000, "R9 single once mid");
        idle(2);
        smp(0, 14'h2000, "R9 single once held");
        useq = 2'b11;
        smp(0, a, "R9 pair once A");
        smp(0, b, "R9 pair once B");
        smp(0, 14'h2000, "R9 pair once mid");
        smp(0, 14'h2000, "R9 pair once held");
        useq = 2'b10;
        smp(0, a, "R10 sequence rewrite restarts");
        useq = 2'b01;
        smp(0, a, "R10 pair restart A");
        useq = 2'b00; tmode = 4'b0000;
    endtask

    task automatic t_fmt;
        logic [13:0] w;
        w = 14'h2ABC;
        tmode = 4'b0000;
        fmt = 2'b01; smp(w, w ^ 14'h2000, "R11 twos complement");
        fmt = 2'b10; smp(w, w ^ (w >> 1), "R11 gray");
        fmt = 2'b11; smp(w, w, "R11 alt offset binary");
        fmt = 2'b00; smp(w, w, "R11 offset binary");
        tmode = 4'b0001; fmt = 2'b01;
        smp(0, 14'h0000, "R11 twos midscale");
        tmode = 4'b0000; fmt = 2'b00;
    endtask

    task automatic t_inv;
        logic [13:0] w;
        w = 14'h1234;
        tmode = 4'b0000; inv_en = 1'b1;
        smp(w, ~w, "R12 invert offset binary");
        fmt = 2'b01; smp(w, ~(w ^ 14'h2000), "R12 invert after twos");
        fmt = 2'b10; smp(w, ~(w ^ (w >> 1)), "R12 invert after gray");
        fmt = 2'b00; tmode = 4'b0011;
        smp(0, 14'h3FFF, "R12 invert negative full");
        inv_en = 1'b0; tmode = 4'b0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_live();
        t_fixed();
        t_alt();
        t_restart();
        t_walk();
        t_pn_long();
        t_pn_short();
        t_user();
        t_fmt();
        t_inv();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule